// File: doc/BRIEF.md
# ECC Error Logger and Counters

This unit sits beside a SECDED memory wrapper and turns its error event pulses into diagnostic history that software can inspect. A corrected single-bit error arrives with the failing address and the corrected codeword bit position. A double-bit error or an address error arrives with its address only. Corrected addresses go into a small trace FIFO that skips any address it already holds. Uncorrectable addresses, from both double-bit and address errors, go into a second trace FIFO.

Three saturating counters count single, double and address error events. Each counter has a programmable threshold, and reaching the threshold sets a sticky exception bit. One sticky bit per codeword position records which bit positions have been corrected. Two level interrupt outputs follow the sticky status. All state is reached through a word-addressed register port with a single-cycle write strobe, a read strobe and a combinational read data path. A control bit turns diagnostics on and off.

Register word addresses: 0 control (bit 0 diagnostics enable, reset 0), 1 status, 2 corrected-trace pop, 3 uncorrectable-trace pop, 4/5/6 single/double/address counters, 7/8/9 the matching thresholds (reset 0), and 10 upward the bit-position history (32 positions per word, position p at word 10+p/32, bit p%32).

Top module: `ecc_diag_logger`

## Requirements
- R1: Each trace FIFO holds DEPTH (default 4) addresses. A read of its pop register returns bit 31 = not empty, bits 18:16 = entry count before the read, and bits 15:0 = the oldest address (0 when empty). It then removes that entry. The corrected trace pop register is word 2 and the uncorrectable one is word 3.
- R2: An accepted corrected error whose address is already held in the corrected trace is not stored again. Once the address has been popped, it is stored again.
- R3: A new address offered to a full trace FIFO is dropped and sets a sticky overflow bit: status bit 2 for the corrected trace and bit 3 for the uncorrectable trace. A duplicate suppressed by R2 is not an overflow.
- R4: Double-bit and address errors both enter the uncorrectable trace, and repeats are kept. When both arrive in the same cycle, only the double-bit address is stored.
- R5: Each accepted event increments its counter, including corrected events suppressed by R2. Writing zero to a counter clears it, and writing a nonzero value has no effect.
- R6: A counter stays at 2^CNT_W-1 (default 255) once it has reached that value.
- R7: When a counter increments to a value equal to its nonzero threshold, the sticky status bit is set: bit 4 for single, bit 5 for double, bit 6 for address. A threshold of 0 never fires.
- R8: An accepted corrected error sets the history bit of its codeword position. A position of CW_BITS (default 137) or above is ignored. Writing a history word clears the bits written as one.
- R9: While the enable bit is 0, the event inputs change no counter, FIFO, history or status bit.
- R10: Status bit 0 is set by an accepted corrected event and bit 1 by an accepted uncorrectable event. irq_corr_o is status bit 0 or bit 4. irq_uncorr_o is status bit 1, bit 5 or bit 6. Writing one to a status bit clears it, and a set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sec_evt_i | input | 1 | Corrected single-bit error pulse |
| sec_addr_i | input | AW | Address of corrected error |
| sec_bit_i | input | clog2(CW_BITS) | Corrected codeword bit position |
| ded_evt_i | input | 1 | Double-bit error pulse |
| ded_addr_i | input | AW | Address of double-bit error |
| aerr_evt_i | input | 1 | Address error pulse |
| aerr_addr_i | input | AW | Address of address error |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops trace FIFOs) |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_corr_o | output | 1 | Correctable-event interrupt |
| irq_uncorr_o | output | 1 | Uncorrectable-event interrupt |

## Verification
The corrected trace is driven with an address sequence that contains a repeat before the FIFO fills, and a new address and a repeat after it fills. The pop order then tells deduplication apart from plain queuing, and tells a true overflow apart from a suppressed duplicate. A sweep over every codeword bit position, followed by out-of-range and single-position events, shows whether the history mapping is complete and whether invalid positions leak into it. Long event runs reach counter saturation, and threshold crossings are checked one event before and at the crossing. On the uncorrectable side, repeated and coincident double-bit and address errors show that no deduplication takes place there and that the double-bit address wins a tie.

// File: rtl/ecc_diag_pkg.sv
package ecc_diag_pkg;
  localparam int REG_AW = 5;
  localparam int REG_DW = 32;
  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  localparam int A_CPOP = 2;
  localparam int A_UPOP = 3;
  localparam int A_CNT0 = 4;
  localparam int A_THR0 = 7;
  localparam int A_HIST = 10;
  localparam int N_CNT  = 3;
  localparam int N_STAT = 7;
  // status bit positions
  localparam int S_CPEND = 0;
  localparam int S_UPEND = 1;
  localparam int S_COVF  = 2;
  localparam int S_UOVF  = 3;
  localparam int S_THR0  = 4;
endpackage

// File: rtl/ecc_trace_fifo.sv
module ecc_trace_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter bit DEDUP = 1'b1,
  localparam int PW   = $clog2(DEPTH),
  localparam int CNW  = PW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  logic [AW-1:0]  addr_i,
  input  logic           pop_i,
  output logic [AW-1:0]  head_o,
  output logic [CNW-1:0] count_o,
  output logic           drop_o
);
  logic [AW-1:0]  mem_q [DEPTH];
  logic [PW-1:0]  rd_q, wr_q;
  logic [CNW-1:0] cnt_q;
  logic [DEPTH-1:0] match;
  logic hit, full, do_push, do_pop;

  // live slots sit at offsets below the count from the read pointer
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic [PW-1:0] off;
    assign off = PW'(i) - rd_q;
    assign match[i] = ({1'b0, off} < cnt_q) && (mem_q[i] == addr_i);
  end

  if (DEDUP) begin : g_dedup
    assign hit = |match;
  end else begin : g_nodedup
    assign hit = 1'b0;
  end

  assign full    = (cnt_q == CNW'(DEPTH));
  assign do_push = push_i && !hit && !full;
  assign drop_o  = push_i && !hit && full;
  assign do_pop  = pop_i && (cnt_q != '0);
  assign head_o  = (cnt_q != '0) ? mem_q[rd_q] : '0;
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + CNW'(do_push) - CNW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= addr_i;
  end
endmodule

// File: rtl/ecc_evt_counter.sv
module ecc_evt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             thr_hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             step;

  assign step      = inc_i && !clr_i && (cnt_q != '1);
  assign cnt_nx    = cnt_q + 1'b1;
  assign thr_hit_o = step && (thr_i != '0) && (cnt_nx == thr_i);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (step)  cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/ecc_bit_history.sv
module ecc_bit_history #(
  parameter int CW_BITS = 137,
  localparam int IW     = $clog2(CW_BITS),
  localparam int NW     = (CW_BITS + 31) / 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [IW-1:0]    idx_i,
  input  logic [NW*32-1:0] clr_i,
  output logic [NW*32-1:0] hist_o
);
  logic [CW_BITS-1:0] hist_q;

  for (genvar b = 0; b < CW_BITS; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           hist_q[b] <= 1'b0;
      else if (set_i && idx_i == IW'(b))     hist_q[b] <= 1'b1;
      else if (clr_i[b])                     hist_q[b] <= 1'b0;
    end
  end

  if (NW * 32 > CW_BITS) begin : g_pad
    assign hist_o = {{(NW*32-CW_BITS){1'b0}}, hist_q};
  end else begin : g_nopad
    assign hist_o = hist_q;
  end
endmodule

// File: rtl/ecc_diag_logger.sv
module ecc_diag_logger
  import ecc_diag_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DEPTH   = 4,
  parameter int CNT_W   = 8,
  parameter int CW_BITS = 137
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sec_evt_i,
  input  logic [AW-1:0]              sec_addr_i,
  input  logic [$clog2(CW_BITS)-1:0] sec_bit_i,
  input  logic                       ded_evt_i,
  input  logic [AW-1:0]              ded_addr_i,
  input  logic                       aerr_evt_i,
  input  logic [AW-1:0]              aerr_addr_i,
  input  logic                       reg_we_i,
  input  logic                       reg_re_i,
  input  logic [REG_AW-1:0]          reg_addr_i,
  input  logic [REG_DW-1:0]          reg_wdata_i,
  output logic [REG_DW-1:0]          reg_rdata_o,
  output logic                       irq_corr_o,
  output logic                       irq_uncorr_o
);
  localparam int NW  = (CW_BITS + 31) / 32;
  localparam int CNW = $clog2(DEPTH) + 1;

  logic              diag_en_q;
  logic [N_STAT-1:0] stat_q, stat_set, stat_clr;
  logic              sec_acc, ded_acc, aerr_acc, unc_acc;
  logic [AW-1:0]     corr_head, unc_head, unc_addr;
  logic [CNW-1:0]    corr_cnt, unc_cnt;
  logic              corr_drop, unc_drop;
  logic              corr_pop, unc_pop;
  logic [CNT_W-1:0]  cnt [N_CNT];
  logic [CNT_W-1:0]  thr_q [N_CNT];
  logic [N_CNT-1:0]  inc, clr, thr_hit;
  logic [NW*32-1:0]  hist, hist_clr;
  int unsigned       ra;

  assign ra       = int'(reg_addr_i);
  assign sec_acc  = diag_en_q && sec_evt_i;
  assign ded_acc  = diag_en_q && ded_evt_i;
  assign aerr_acc = diag_en_q && aerr_evt_i;
  assign unc_acc  = ded_acc || aerr_acc;
  assign unc_addr = ded_acc ? ded_addr_i : aerr_addr_i;
  assign corr_pop = reg_re_i && ra == A_CPOP;
  assign unc_pop  = reg_re_i && ra == A_UPOP;

  ecc_trace_fifo #(.DEPTH(DEPTH), .AW(AW), .DEDUP(1'b1)) u_corr_fifo (
    .clk_i, .rst_ni,
    .push_i(sec_acc), .addr_i(sec_addr_i), .pop_i(corr_pop),
    .head_o(corr_head), .count_o(corr_cnt), .drop_o(corr_drop)
  );

  ecc_trace_fifo #(.DEPTH(DEPTH), .AW(AW), .DEDUP(1'b0)) u_unc_fifo (
    .clk_i, .rst_ni,
    .push_i(unc_acc), .addr_i(unc_addr), .pop_i(unc_pop),
    .head_o(unc_head), .count_o(unc_cnt), .drop_o(unc_drop)
  );

  assign inc = {aerr_acc, ded_acc, sec_acc};

  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    assign clr[k] = reg_we_i && ra == A_CNT0 + k && reg_wdata_i == '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              thr_q[k] <= '0;
      else if (reg_we_i && ra == A_THR0 + k)    thr_q[k] <= reg_wdata_i[CNT_W-1:0];
    end

    ecc_evt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i, .rst_ni,
      .inc_i(inc[k]), .clr_i(clr[k]), .thr_i(thr_q[k]),
      .cnt_o(cnt[k]), .thr_hit_o(thr_hit[k])
    );
  end

  for (genvar w = 0; w < NW; w++) begin : g_hclr
    assign hist_clr[w*32 +: 32] = (reg_we_i && ra == A_HIST + w) ? reg_wdata_i : '0;
  end

  ecc_bit_history #(.CW_BITS(CW_BITS)) u_hist (
    .clk_i, .rst_ni,
    .set_i(sec_acc), .idx_i(sec_bit_i), .clr_i(hist_clr), .hist_o(hist)
  );

  always_comb begin
    stat_set = '0;
    stat_set[S_CPEND] = sec_acc;
    stat_set[S_UPEND] = unc_acc;
    stat_set[S_COVF]  = corr_drop;
    stat_set[S_UOVF]  = unc_drop;
    stat_set[S_THR0 +: N_CNT] = thr_hit;
    stat_clr = (reg_we_i && ra == A_STAT) ? reg_wdata_i[N_STAT-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      diag_en_q <= 1'b0;
      stat_q    <= '0;
    end else begin
      if (reg_we_i && ra == A_CTRL) diag_en_q <= reg_wdata_i[0];
      stat_q <= (stat_q & ~stat_clr) | stat_set;
    end
  end

  assign irq_corr_o   = stat_q[S_CPEND] | stat_q[S_THR0];
  assign irq_uncorr_o = stat_q[S_UPEND] | stat_q[S_THR0+1] | stat_q[S_THR0+2];

  always_comb begin
    reg_rdata_o = '0;
    if (ra == A_CTRL) reg_rdata_o[0] = diag_en_q;
    if (ra == A_STAT) reg_rdata_o[N_STAT-1:0] = stat_q;
    if (ra == A_CPOP) begin
      reg_rdata_o[31]        = corr_cnt != '0;
      reg_rdata_o[16 +: CNW] = corr_cnt;
      reg_rdata_o[AW-1:0]    = corr_head;
    end
    if (ra == A_UPOP) begin
      reg_rdata_o[31]        = unc_cnt != '0;
      reg_rdata_o[16 +: CNW] = unc_cnt;
      reg_rdata_o[AW-1:0]    = unc_head;
    end
    for (int k = 0; k < N_CNT; k++) begin
      if (ra == A_CNT0 + k) reg_rdata_o[CNT_W-1:0] = cnt[k];
      if (ra == A_THR0 + k) reg_rdata_o[CNT_W-1:0] = thr_q[k];
    end
    for (int w = 0; w < NW; w++) begin
      if (ra == A_HIST + w) reg_rdata_o = hist[w*32 +: 32];
    end
  end
endmodule

// File: rtl/ecc_diag_logger_chk.sv
module ecc_diag_logger_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 8,
  localparam int CNW  = $clog2(DEPTH) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             diag_en,
  input logic             sec_evt_i,
  input logic             reg_re_i,
  input logic [CNW-1:0]   corr_cnt,
  input logic [CNT_W-1:0] sec_cnt,
  input logic             sec_clr,
  input logic             corr_ovf,
  input logic             irq_corr_o
);
  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_cnt <= CNW'(DEPTH)); // R1

  AST_OVF_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(corr_ovf) |-> $past(corr_cnt) == CNW'(DEPTH)); // R3

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_cnt != $past(sec_cnt)) |-> (sec_cnt == '0 || sec_cnt == CNT_W'($past(sec_cnt) + 1'b1))); // R5

  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sec_cnt) == {CNT_W{1'b1}} && !$past(sec_clr)) |-> sec_cnt == {CNT_W{1'b1}}); // R6

  AST_DIS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(diag_en) && !$past(reg_re_i)) |-> corr_cnt == $past(corr_cnt)); // R9

  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_corr_o) |-> $past(sec_evt_i && diag_en)); // R10
endmodule

bind ecc_diag_logger ecc_diag_logger_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .diag_en(diag_en_q), .sec_evt_i(sec_evt_i),
  .reg_re_i(reg_re_i), .corr_cnt(corr_cnt), .sec_cnt(cnt[0]), .sec_clr(clr[0]),
  .corr_ovf(stat_q[2]), .irq_corr_o(irq_corr_o)
);

// File: tb/ecc_diag_logger_bench.sv
module ecc_diag_logger_bench;
  localparam int CWB = 137;
  localparam logic [4:0] CTRL = 0, STAT = 1, CPOP = 2, UPOP = 3,
                         SCNT = 4, DCNT = 5, ACNT = 6, STHR = 7, ATHR = 9, HIST = 10;

  logic clk = 0, rst_ni = 0;
  logic sec_evt = 0, ded_evt = 0, aerr_evt = 0;
  logic [15:0] sec_addr = 0, ded_addr = 0, aerr_addr = 0;
  logic [7:0] sec_bit = 0;
  logic we = 0, re = 0;
  logic [4:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq_c, irq_u;
  int nvec = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ecc_diag_logger u_ecc_diag_logger (
    .clk_i(clk), .rst_ni(rst_ni),
    .sec_evt_i(sec_evt), .sec_addr_i(sec_addr), .sec_bit_i(sec_bit),
    .ded_evt_i(ded_evt), .ded_addr_i(ded_addr),
    .aerr_evt_i(aerr_evt), .aerr_addr_i(aerr_addr),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_corr_o(irq_c), .irq_uncorr_o(irq_u)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(posedge clk); #1 we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1;
    #1 d = rdata;
    @(posedge clk); #1 re = 0;
  endtask

  task automatic rdchk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic ev(input logic s, input logic [15:0] sa, input logic [7:0] sb,
                    input logic d, input logic [15:0] da,
                    input logic e, input logic [15:0] ea);
    @(negedge clk);
    sec_evt = s; sec_addr = sa; sec_bit = sb;
    ded_evt = d; ded_addr = da; aerr_evt = e; aerr_addr = ea;
    @(negedge clk);
    sec_evt = 0; ded_evt = 0; aerr_evt = 0;
  endtask

  task automatic sec(input logic [15:0] a, input logic [7:0] b);
    ev(1, a, b, 0, 0, 0, 0);
  endtask

  function automatic logic [31:0] pop_word(input int n, input logic [15:0] a);
    return {1'b1, 12'd0, 3'(n), a};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // reset state
    rdchk("R1 reset ctrl", CTRL, 0);
    rdchk("R10 reset stat", STAT, 0);
    rdchk("R1 reset cpop", CPOP, 0);
    chk("R10 reset irq", {irq_c, irq_u}, 0);

    // disabled: events ignored
    ev(1, 16'h5, 8'd3, 1, 16'h6, 1, 16'h7);
    rdchk("R9 scnt", SCNT, 0);
    rdchk("R9 dcnt", DCNT, 0);
    rdchk("R9 cpop", CPOP, 0);
    rdchk("R9 upop", UPOP, 0);
    rdchk("R9 hist", HIST, 0);
    rdchk("R9 stat", STAT, 0);

    wr(CTRL, 1);
    wr(STHR, 3);
    // corrected trace: dup before full, drop at full, dup at full
    sec(16'h10, 0); sec(16'h20, 0); sec(16'h10, 0); sec(16'h30, 0);
    sec(16'h40, 0); sec(16'h50, 0); sec(16'h20, 0);
    rdchk("R3 R7 stat", STAT, 32'h15);
    chk("R10 irq_corr", {irq_c, irq_u}, 2'b10);
    rdchk("R5 scnt dup counted", SCNT, 7);
    rdchk("R2 pop0", CPOP, pop_word(4, 16'h10));
    rdchk("R2 pop1", CPOP, pop_word(3, 16'h20));
    rdchk("R2 pop2", CPOP, pop_word(2, 16'h30));
    rdchk("R1 pop3", CPOP, pop_word(1, 16'h40));
    rdchk("R1 empty", CPOP, 0);
    sec(16'h10, 0);
    rdchk("R2 re-record", CPOP, pop_word(1, 16'h10));
    wr(STAT, 32'h04);
    rdchk("R10 partial w1c", STAT, 32'h11);
    wr(STAT, 32'h11);
    rdchk("R10 w1c", STAT, 0);
    chk("R10 irq low", {irq_c, irq_u}, 0);
    wr(SCNT, 5);
    rdchk("R5 nonzero write ignored", SCNT, 8);
    wr(SCNT, 0);
    rdchk("R5 clear", SCNT, 0);

    // bit history sweep
    wr(HIST, 32'hffff_ffff);
    for (int b = 0; b < CWB; b++) sec(16'h77, 8'(b));
    for (int w = 0; w < 4; w++) rdchk("R8 hist full", HIST + 5'(w), 32'hffff_ffff);
    rdchk("R8 hist top", HIST + 5'd4, 32'h1ff);
    rdchk("R5 scnt sweep", SCNT, CWB);
    for (int w = 0; w < 5; w++) wr(HIST + 5'(w), 32'hffff_ffff);
    sec(16'h77, 8'd200);
    rdchk("R8 out of range w0", HIST, 0);
    rdchk("R8 out of range w4", HIST + 5'd4, 0);
    sec(16'h77, 8'd37);
    rdchk("R8 pos37", HIST + 5'd1, 32'h20);
    rdchk("R8 pos37 w0", HIST, 0);

    // saturation
    for (int i = 0; i < 130; i++) sec(16'h77, 0);
    rdchk("R6 saturate", SCNT, 255);
    sec(16'h77, 0);
    rdchk("R6 hold", SCNT, 255);

    // threshold crossing
    wr(STAT, 32'h7f);
    wr(SCNT, 0);
    wr(STHR, 4);
    for (int i = 0; i < 3; i++) sec(16'h77, 0);
    rdchk("R7 below thr", STAT, 32'h01);
    sec(16'h77, 0);
    rdchk("R7 at thr", STAT, 32'h11);

    // uncorrectable trace
    wr(STAT, 32'h7f);
    wr(ATHR, 3);
    ev(0, 0, 0, 1, 16'hA, 0, 0);
    ev(0, 0, 0, 1, 16'hA, 0, 0);
    ev(0, 0, 0, 1, 16'hC, 1, 16'hD);
    ev(0, 0, 0, 0, 0, 1, 16'hB);
    ev(0, 0, 0, 0, 0, 1, 16'hE);
    rdchk("R4 R3 R7 stat", STAT, 32'h4A);
    chk("R10 irq_uncorr", {irq_c, irq_u}, 2'b01);
    rdchk("R4 dcnt", DCNT, 3);
    rdchk("R4 acnt", ACNT, 3);
    rdchk("R4 upop0", UPOP, pop_word(4, 16'hA));
    rdchk("R4 upop1 repeat kept", UPOP, pop_word(3, 16'hA));
    rdchk("R4 upop2 tie", UPOP, pop_word(2, 16'hC));
    rdchk("R4 upop3", UPOP, pop_word(1, 16'hB));
    rdchk("R3 upop empty", UPOP, 0);
    wr(STAT, 32'h7f);
    chk("R10 irq clear", {irq_c, irq_u}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule